// File: doc/BRIEF.md
# System Controller Register Bank

A 32-bit memory-mapped register bank for the control plane of a small SoC. A single word-addressed port reaches GPIO output and interrupt-enable storage, a synchronized GPIO input word, a parameterized set of timer channels, a scratch word, a sticky lock flag, a configuration-port command word, and three read-only identification words: clock rate, feature bits and system identifier. The timer counting engines sit outside this block. Only their control and compare fields, their counter load strobe and their live count come through here.

Some writes have side effects. A write to the identifier word leaves that word unchanged and raises a one-cycle system-reset request. A write to the command word whose low half carries the halt code raises a one-cycle shutdown request. Any write to the lock word sets the flag, and only reset clears it. The bank flags every malformed or illegal access with a one-cycle error pulse. A change on an enabled GPIO input raises a one-cycle interrupt pulse.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word 0 reads 0x00000001, word 16 reads 0x00000001, word 29 reads 0x04C4B400 (80,000,000), word 30 reads 0 and word 31 reads 0x10014D31. The GPIO output, interrupt-enable, scratch, lock and timer words all read 0.
- R2: The word index is `bus_addr` shifted right by two. Read data and the error flag are registered and appear in the cycle after the strobe. A read of an unmapped word (3, 7, 11-15, 17-19, 22-28, 32 and up) returns 0 and raises `bus_err` for one cycle.
- R3: Only full-word accesses are legal: `bus_be` must be 4'b1111 and `bus_addr[1:0]` must be 0. Any other access raises `bus_err`. A write of this kind changes nothing, and a read of this kind returns 0.
- R4: Word 1 holds the GPIO output, driven on `gpio_out`. Word 2 holds the GPIO interrupt enables. Word 20 is a 32-bit scratch word. Each reads back the value written.
- R5: Words 0, 29 and 30 are read-only. A write to any of them is dropped and raises `bus_err`.
- R6: Any write to word 21 sets the lock flag whatever the data. Word 21 reads the flag in bit 0 with zeros above it. Only reset clears the flag.
- R7: Any full-word write to word 31 pulses `rst_req` for exactly one cycle, without `bus_err`. Word 31 keeps its identifier value.
- R8: A full-word write to word 16 whose data bits [15:0] equal 0x000E pulses `shut_req` for one cycle. Any other data has no effect. Word 16 always reads 0x00000001.
- R9: Timer channel c occupies words 4c+4, 4c+5 and 4c+6. The first is control (bit 0 run, bit 1 auto-restart, upper bits read 0), the second is compare, the third is counter. A counter write pulses `tmr_load[c]` for one cycle with the data on `tmr_load_val`. A counter read returns `tmr_count` slice c.
- R10: When `tmr_hit[c]` arrives while channel c has run=1 and auto-restart=0, the run bit clears. With auto-restart=1 the control word is unchanged. A control write in the same cycle as a hit takes precedence over the hit.
- R11: GPIO inputs pass through a two-flop synchronizer before they are read at word 0. A change on an input bit whose enable is set gives exactly one single-cycle `gpio_irq` pulse. A change on a disabled bit gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle access error flag |
| gpio_in | input | GPIO_W | Asynchronous GPIO inputs |
| gpio_out | output | GPIO_W | GPIO output register |
| gpio_irq | output | 1 | GPIO change interrupt pulse |
| tmr_ctrl | output | 2*N_TMR | Per-channel control bits {restart, run} |
| tmr_cmp | output | 32*N_TMR | Per-channel compare values |
| tmr_load | output | N_TMR | Per-channel counter load strobe |
| tmr_load_val | output | 32 | Counter load value |
| tmr_count | input | 32*N_TMR | Live per-channel count values |
| tmr_hit | input | N_TMR | Per-channel compare-match event |
| rst_req | output | 1 | System reset request pulse |
| shut_req | output | 1 | Shutdown request pulse |

## Verification
A corrupted decode shows on the very next cycle, as read data from the wrong word or an error flag missing or misplaced for that access. A stuck or mis-latched storage bit shows on the next read of its word. For GPIO output and timer fields it shows at once on the dedicated outputs. A wrong lock, request or timer run bit is caught on the next read or in the pulse cycle itself. Synchronizer or edge-detect faults show as a missing, doubled or spurious `gpio_irq` within three cycles of an input change.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW         = 32;
    localparam int TMR_STRIDE = 4;

    localparam logic [29:0] WD_GPIN  = 30'd0;
    localparam logic [29:0] WD_GPOUT = 30'd1;
    localparam logic [29:0] WD_GPIEN = 30'd2;
    localparam logic [29:0] WD_TMR0  = 30'd4;
    localparam logic [29:0] WD_CFG   = 30'd16;
    localparam logic [29:0] WD_SCR   = 30'd20;
    localparam logic [29:0] WD_LOCK  = 30'd21;
    localparam logic [29:0] WD_FREQ  = 30'd29;
    localparam logic [29:0] WD_CAPS  = 30'd30;
    localparam logic [29:0] WD_ID    = 30'd31;

    localparam logic [15:0] HALT_CODE = 16'h000E;
    localparam logic [DW-1:0] CFG_READY = 32'h0000_0001;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_GPIN, SEL_GPOUT, SEL_GPIEN,
        SEL_TCTRL, SEL_TCMP, SEL_TCNT,
        SEL_CFG, SEL_SCR, SEL_LOCK,
        SEL_FREQ, SEL_CAPS, SEL_ID
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [3:0] ch;
    } reg_dec_t;

    typedef struct packed {
        logic restart;
        logic run;
    } tmr_ctrl_t;

    // Word index to register select; timer words occupy a stride of four
    // starting at word 4, with the fourth word of each stride unmapped.
    function automatic reg_dec_t decode_word(input logic [29:0] w, input int n_tmr);
        reg_dec_t d;
        d.sel = SEL_NONE;
        d.ch  = '0;
        case (w)
            WD_GPIN:  d.sel = SEL_GPIN;
            WD_GPOUT: d.sel = SEL_GPOUT;
            WD_GPIEN: d.sel = SEL_GPIEN;
            WD_CFG:   d.sel = SEL_CFG;
            WD_SCR:   d.sel = SEL_SCR;
            WD_LOCK:  d.sel = SEL_LOCK;
            WD_FREQ:  d.sel = SEL_FREQ;
            WD_CAPS:  d.sel = SEL_CAPS;
            WD_ID:    d.sel = SEL_ID;
            default: begin
                if (w >= WD_TMR0 && w < WD_TMR0 + 30'(TMR_STRIDE * n_tmr)
                    && w[1:0] != 2'd3) begin
                    d.ch = 4'((w - WD_TMR0) >> 2);
                    case (w[1:0])
                        2'd0:    d.sel = SEL_TCTRL;
                        2'd1:    d.sel = SEL_TCMP;
                        default: d.sel = SEL_TCNT;
                    endcase
                end
            end
        endcase
        return d;
    endfunction

    function automatic logic is_read_only(input reg_sel_e s);
        return (s == SEL_GPIN) || (s == SEL_FREQ) || (s == SEL_CAPS);
    endfunction

    function automatic logic is_full_word(input logic [3:0] be, input logic [1:0] lo);
        return (be == 4'hF) && (lo == 2'b00);
    endfunction

endpackage

// File: rtl/sysctl_gpio.sv
module sysctl_gpio #(
    parameter int          W     = 8,
    parameter logic [W-1:0] STRAP = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] ien_i,
    output logic [W-1:0] val_o,
    output logic         irq_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;
    logic         irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= STRAP;
            sync_q <= STRAP;
            prev_q <= STRAP;
            irq_q  <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
            irq_q  <= |((sync_q ^ prev_q) & ien_i);
        end
    end

    assign val_o = sync_q;
    assign irq_o = irq_q;
endmodule

// File: rtl/sysctl_tmr_chan.sv
module sysctl_tmr_chan
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_cmp,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    input  logic          hit_i,
    output tmr_ctrl_t     ctrl_o,
    output logic [DW-1:0] cmp_o,
    output logic          load_o
);
    tmr_ctrl_t     ctrl_q;
    logic [DW-1:0] cmp_q;
    logic          load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            load_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= tmr_ctrl_t'(wdata[1:0]);
            end else if (hit_i && ctrl_q.run && !ctrl_q.restart) begin
                ctrl_q.run <= 1'b0;
            end
            if (wr_cmp) begin
                cmp_q <= wdata;
            end
            load_q <= wr_cnt;
        end
    end

    assign ctrl_o = ctrl_q;
    assign cmp_o  = cmp_q;
    assign load_o = load_q;
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
    import sysctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_id,
    input  logic        wr_cfg,
    input  logic [15:0] cfg_code,
    input  logic        wr_lock,
    output logic        rst_req_o,
    output logic        shut_req_o,
    output logic        lock_o
);
    logic rst_req_q;
    logic shut_req_q;
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q  <= 1'b0;
            shut_req_q <= 1'b0;
            lock_q     <= 1'b0;
        end else begin
            rst_req_q  <= wr_id;
            shut_req_q <= wr_cfg && (cfg_code == HALT_CODE);
            if (wr_lock) begin
                lock_q <= 1'b1;
            end
        end
    end

    assign rst_req_o  = rst_req_q;
    assign shut_req_o = shut_req_q;
    assign lock_o     = lock_q;
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          GPIO_W     = 8,
    parameter int          N_TMR      = 2,   // at most 3 so timers stay below word 16
    parameter logic [31:0] SYS_ID     = 32'h1001_4D31,
    parameter logic [31:0] CLK_HZ     = 32'd80_000_000,
    parameter logic [31:0] CAPS       = 32'h0000_0000,
    parameter logic [31:0] GPIO_STRAP = 32'h0000_0001
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [3:0]            bus_be,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_err,
    input  logic [GPIO_W-1:0]     gpio_in,
    output logic [GPIO_W-1:0]     gpio_out,
    output logic                  gpio_irq,
    output logic [2*N_TMR-1:0]    tmr_ctrl,
    output logic [32*N_TMR-1:0]   tmr_cmp,
    output logic [N_TMR-1:0]      tmr_load,
    output logic [31:0]           tmr_load_val,
    input  logic [32*N_TMR-1:0]   tmr_count,
    input  logic [N_TMR-1:0]      tmr_hit,
    output logic                  rst_req,
    output logic                  shut_req
);
    localparam int WORD_W = ADDR_W - 2;

    // ---------------- access decode ----------------
    logic [29:0] word_idx;
    reg_dec_t    dec;
    logic        full_acc;
    logic        acc_ok;
    logic        ro_hit;
    logic        wr_ok;
    logic        err_d;

    assign word_idx = 30'(bus_addr[ADDR_W-1:2]);
    assign dec      = decode_word(word_idx, N_TMR);
    assign full_acc = is_full_word(bus_be, bus_addr[1:0]);
    assign acc_ok   = full_acc && (dec.sel != SEL_NONE);
    assign ro_hit   = is_read_only(dec.sel);
    assign wr_ok    = bus_wr && acc_ok && !ro_hit;
    assign err_d    = ((bus_rd || bus_wr) && !acc_ok) || (bus_wr && acc_ok && ro_hit);

    // ---------------- plain storage ----------------
    logic [GPIO_W-1:0] gpout_q;
    logic [GPIO_W-1:0] gpien_q;
    logic [31:0]       scratch_q;
    logic [31:0]       load_val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gpout_q    <= '0;
            gpien_q    <= '0;
            scratch_q  <= '0;
            load_val_q <= '0;
        end else if (wr_ok) begin
            case (dec.sel)
                SEL_GPOUT: gpout_q    <= bus_wdata[GPIO_W-1:0];
                SEL_GPIEN: gpien_q    <= bus_wdata[GPIO_W-1:0];
                SEL_SCR:   scratch_q  <= bus_wdata;
                SEL_TCNT:  load_val_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // ---------------- GPIO input path ----------------
    logic [GPIO_W-1:0] gpin_val;

    sysctl_gpio #(
        .W     (GPIO_W),
        .STRAP (GPIO_STRAP[GPIO_W-1:0])
    ) u_gpio (
        .clk   (clk),
        .rst   (rst),
        .pin_i (gpio_in),
        .ien_i (gpien_q),
        .val_o (gpin_val),
        .irq_o (gpio_irq)
    );

    // ---------------- timer channels ----------------
    tmr_ctrl_t   ctrl_a [N_TMR];
    logic [31:0] cmp_a  [N_TMR];

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        logic sel_ch;
        assign sel_ch = wr_ok && (dec.ch == 4'(g));

        sysctl_tmr_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_ctrl (sel_ch && dec.sel == SEL_TCTRL),
            .wr_cmp  (sel_ch && dec.sel == SEL_TCMP),
            .wr_cnt  (sel_ch && dec.sel == SEL_TCNT),
            .wdata   (bus_wdata),
            .hit_i   (tmr_hit[g]),
            .ctrl_o  (ctrl_a[g]),
            .cmp_o   (cmp_a[g]),
            .load_o  (tmr_load[g])
        );

        assign tmr_ctrl[2*g +: 2] = ctrl_a[g];
        assign tmr_cmp[32*g +: 32] = cmp_a[g];
    end

    // ---------------- side-effect commands ----------------
    logic lock_flag;

    sysctl_cmd u_cmd (
        .clk        (clk),
        .rst        (rst),
        .wr_id      (bus_wr && full_acc && dec.sel == SEL_ID),
        .wr_cfg     (wr_ok && dec.sel == SEL_CFG),
        .cfg_code   (bus_wdata[15:0]),
        .wr_lock    (wr_ok && dec.sel == SEL_LOCK),
        .rst_req_o  (rst_req),
        .shut_req_o (shut_req),
        .lock_o     (lock_flag)
    );

    // ---------------- read mux ----------------
    logic [31:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (dec.sel)
            SEL_GPIN:  rd_val = 32'(gpin_val);
            SEL_GPOUT: rd_val = 32'(gpout_q);
            SEL_GPIEN: rd_val = 32'(gpien_q);
            SEL_CFG:   rd_val = CFG_READY;
            SEL_SCR:   rd_val = scratch_q;
            SEL_LOCK:  rd_val = {31'b0, lock_flag};
            SEL_FREQ:  rd_val = CLK_HZ;
            SEL_CAPS:  rd_val = CAPS;
            SEL_ID:    rd_val = SYS_ID;
            SEL_TCTRL, SEL_TCMP, SEL_TCNT: begin
                for (int i = 0; i < N_TMR; i++) begin
                    if (dec.ch == 4'(i)) begin
                        if (dec.sel == SEL_TCTRL)     rd_val = {30'b0, ctrl_a[i]};
                        else if (dec.sel == SEL_TCMP) rd_val = cmp_a[i];
                        else                          rd_val = tmr_count[32*i +: 32];
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

    logic [31:0] rdata_q;
    logic        err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= (bus_rd && acc_ok) ? rd_val : '0;
            err_q   <= err_d;
        end
    end

    assign bus_rdata    = rdata_q;
    assign bus_err      = err_q;
    assign gpio_out     = gpout_q;
    assign tmr_load_val = load_val_q;

    logic unused_word_hi;
    assign unused_word_hi = (WORD_W > 30);
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [3:0]        bus_be,
    input logic [15:0]       wdata_lo,
    input logic              bus_err,
    input logic              rst_req,
    input logic              shut_req,
    input logic              lock_flag
);
    localparam logic [ADDR_W-1:0] ID_ADDR  = ADDR_W'(31 * 4);
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(16 * 4);

    // R7: a reset request only follows a full-word write to the identifier word
    assert_id_write_R7: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(bus_wr && bus_be == 4'hF && bus_addr == ID_ADDR));

    // R7: the identifier write is legal, so no error accompanies the request
    assert_rst_no_err_R7: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && bus_err));

    // R8: a shutdown request only follows the halt code written to word 16
    assert_halt_code_R8: assert property (@(posedge clk) disable iff (rst)
        shut_req |-> $past(bus_wr && bus_be == 4'hF && bus_addr == CFG_ADDR
                           && wdata_lo == 16'h000E));

    // R6: once set, the lock flag stays set
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        lock_flag |=> lock_flag);

    // R2: an error flag always follows some access strobe
    assert_err_cause_R2: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_rd || bus_wr));

    // R3: a partial-word access is always flagged in the next cycle
    assert_partial_err_R3: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_be != 4'hF) |=> bus_err);
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .wdata_lo  (bus_wdata[15:0]),
    .bus_err   (bus_err),
    .rst_req   (rst_req),
    .shut_req  (shut_req),
    .lock_flag (lock_flag)
);

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  gpio_in = 8'h01;
    logic [7:0]  gpio_out;
    logic        gpio_irq;
    logic [3:0]  tmr_ctrl;
    logic [63:0] tmr_cmp;
    logic [1:0]  tmr_load;
    logic [31:0] tmr_load_val;
    logic [63:0] tmr_count = {32'hCAFE_0001, 32'h0000_1234};
    logic [1:0]  tmr_hit = '0;
    logic        rst_req;
    logic        shut_req;

    always #4 clk = ~clk;

    sysctl_regbank i_sysctl_regbank (
        .clk, .rst, .bus_addr, .bus_rd, .bus_wr, .bus_be, .bus_wdata,
        .bus_rdata, .bus_err, .gpio_in, .gpio_out, .gpio_irq,
        .tmr_ctrl, .tmr_cmp, .tmr_load, .tmr_load_val, .tmr_count,
        .tmr_hit, .rst_req, .shut_req
    );

    int total = 0;
    int fails = 0;
    logic [31:0] got_rdata;
    logic        got_err, got_rst, got_shut;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic r, input logic [7:0] a,
                       input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        got_rdata = bus_rdata; got_err = bus_err;
        got_rst = rst_req; got_shut = shut_req;
    endtask

    task automatic rd_word(input int w, input logic [31:0] exp, input string tag);
        acc(1'b0, 1'b1, 8'(w * 4), 4'hF, '0);
        chk(got_rdata == exp && !got_err, tag, got_rdata, exp);
    endtask

    // {is_write, word, data, expected read, expected error}
    localparam int NV = 20;
    localparam logic [71:0] VEC [NV] = '{
        {1'b1, 6'd1,  32'h0000_00A5, 32'h0,          1'b0},  // R4
        {1'b0, 6'd1,  32'h0,         32'h0000_00A5,  1'b0},  // R4
        {1'b1, 6'd2,  32'h0000_00FF, 32'h0,          1'b0},  // R4
        {1'b0, 6'd2,  32'h0,         32'h0000_00FF,  1'b0},  // R4
        {1'b1, 6'd20, 32'hDEAD_BEEF, 32'h0,          1'b0},  // R4
        {1'b0, 6'd20, 32'h0,         32'hDEAD_BEEF,  1'b0},  // R4
        {1'b1, 6'd29, 32'h0000_1234, 32'h0,          1'b1},  // R5
        {1'b0, 6'd29, 32'h0,         32'h04C4_B400,  1'b0},  // R5
        {1'b1, 6'd30, 32'h0000_0005, 32'h0,          1'b1},  // R5
        {1'b0, 6'd30, 32'h0,         32'h0,          1'b0},  // R5
        {1'b0, 6'd3,  32'h0,         32'h0,          1'b1},  // R2
        {1'b0, 6'd25, 32'h0,         32'h0,          1'b1},  // R2
        {1'b1, 6'd5,  32'h0000_0100, 32'h0,          1'b0},  // R9
        {1'b0, 6'd5,  32'h0,         32'h0000_0100,  1'b0},  // R9
        {1'b1, 6'd4,  32'hFFFF_FFFF, 32'h0,          1'b0},  // R9
        {1'b0, 6'd4,  32'h0,         32'h0000_0003,  1'b0},  // R9
        {1'b1, 6'd9,  32'h0000_0055, 32'h0,          1'b0},  // R9
        {1'b0, 6'd9,  32'h0,         32'h0000_0055,  1'b0},  // R9
        {1'b1, 6'd12, 32'h0,         32'h0,          1'b1},  // R2
        {1'b0, 6'd16, 32'h0,         32'h0000_0001,  1'b0}   // R8
    };

    int irq_cnt;

    task automatic count_irq(input int cycles);
        irq_cnt = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (gpio_irq) irq_cnt++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_word(0,  32'h0000_0001, "R1 gpio in strap");
        rd_word(16, 32'h0000_0001, "R1 cfg ready");
        rd_word(29, 32'h04C4_B400, "R1 clock rate");
        rd_word(30, 32'h0,         "R1 caps");
        rd_word(31, 32'h1001_4D31, "R1 system id");
        rd_word(1,  32'h0,         "R1 gpio out");
        rd_word(20, 32'h0,         "R1 scratch");
        rd_word(21, 32'h0,         "R1 lock");
        rd_word(4,  32'h0,         "R1 timer ctrl");

        for (int v = 0; v < NV; v++) begin
            logic        is_w;
            logic [5:0]  w;
            logic [31:0] d, e;
            logic        ee;
            {is_w, w, d, e, ee} = VEC[v];
            acc(is_w, !is_w, {w, 2'b00}, 4'hF, d);
            chk(got_err == ee, $sformatf("vector %0d error", v), 32'(got_err), 32'(ee));
            if (!is_w)
                chk(got_rdata == e, $sformatf("vector %0d data", v), got_rdata, e);
        end
        chk(gpio_out == 8'hA5, "R4 gpio_out pin", 32'(gpio_out), 32'hA5);
        chk(tmr_cmp[31:0] == 32'h100, "R9 compare pin", tmr_cmp[31:0], 32'h100);

        // R3 partial and misaligned accesses
        acc(1'b1, 1'b0, 8'd80, 4'b0011, 32'h0);
        chk(got_err, "R3 partial write err", 32'(got_err), 32'h1);
        acc(1'b1, 1'b0, 8'd81, 4'hF, 32'h0);
        chk(got_err, "R3 misaligned write err", 32'(got_err), 32'h1);
        acc(1'b0, 1'b1, 8'd80, 4'b0111, 32'h0);
        chk(got_err && got_rdata == 0, "R3 partial read", got_rdata, 32'h0);
        rd_word(20, 32'hDEAD_BEEF, "R3 scratch intact");

        // R6 lock
        acc(1'b1, 1'b0, 8'd84, 4'hF, 32'h0);
        rd_word(21, 32'h1, "R6 lock set by zero data");
        acc(1'b1, 1'b0, 8'd84, 4'hF, 32'hFFFF_FFFE);
        rd_word(21, 32'h1, "R6 lock stays");

        // R7 identifier write
        acc(1'b1, 1'b0, 8'd124, 4'hF, 32'h0);
        chk(got_rst && !got_err, "R7 reset pulse", 32'(got_rst), 32'h1);
        @(negedge clk);
        chk(!rst_req, "R7 pulse one cycle", 32'(rst_req), 32'h0);
        rd_word(31, 32'h1001_4D31, "R7 id unchanged");

        // R8 command word
        acc(1'b1, 1'b0, 8'd64, 4'hF, 32'hABCD_000E);
        chk(got_shut, "R8 halt code", 32'(got_shut), 32'h1);
        @(negedge clk);
        chk(!shut_req, "R8 pulse one cycle", 32'(shut_req), 32'h0);
        acc(1'b1, 1'b0, 8'd64, 4'hF, 32'h0000_000F);
        chk(!got_shut, "R8 other code ignored", 32'(got_shut), 32'h0);
        rd_word(16, 32'h1, "R8 ready readback");

        // R9 counter load and live read
        acc(1'b1, 1'b0, 8'd24, 4'hF, 32'h0000_0077);
        chk(tmr_load == 2'b01 && tmr_load_val == 32'h77, "R9 load strobe",
            {30'b0, tmr_load}, 32'h1);
        @(negedge clk);
        chk(tmr_load == 2'b00, "R9 load one cycle", {30'b0, tmr_load}, 32'h0);
        rd_word(10, 32'hCAFE_0001, "R9 ch1 count read");
        rd_word(6,  32'h0000_1234, "R9 ch0 count read");

        // R10 hit behaviour (ch0 control is 3 from the vector table)
        @(negedge clk); tmr_hit = 2'b01;
        @(negedge clk); tmr_hit = 2'b00;
        rd_word(4, 32'h3, "R10 restart keeps run");
        acc(1'b1, 1'b0, 8'd16, 4'hF, 32'h1);
        @(negedge clk); tmr_hit = 2'b01;
        @(negedge clk); tmr_hit = 2'b00;
        chk(tmr_ctrl[1:0] == 2'b00, "R10 one-shot clears run", 32'(tmr_ctrl[1:0]), 32'h0);
        rd_word(4, 32'h0, "R10 one-shot readback");
        @(negedge clk);
        tmr_hit = 2'b01; bus_wr = 1'b1; bus_addr = 8'd16; bus_be = 4'hF; bus_wdata = 32'h1;
        @(negedge clk);
        tmr_hit = 2'b00; bus_wr = 1'b0;
        rd_word(4, 32'h1, "R10 write wins over hit");

        // R11 synchronizer and change interrupt
        acc(1'b1, 1'b0, 8'd8, 4'hF, 32'h0F);
        @(negedge clk); gpio_in = 8'h03;
        count_irq(8);
        chk(irq_cnt == 1, "R11 enabled change", 32'(irq_cnt), 32'h1);
        @(negedge clk); gpio_in = 8'h43;
        count_irq(8);
        chk(irq_cnt == 0, "R11 disabled change", 32'(irq_cnt), 32'h0);
        rd_word(0, 32'h43, "R11 synced input");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule